// File: doc/BRIEF.md
# Metadata-Free Line Classifier and Corrector

This block sits on the memory read path. It takes a 512-bit line fetched from memory and decides, with no stored tag bit, whether the line holds compressed data protected by an inline error-correcting code or raw data kept as written. The line is cut into four 128-bit chunks, each of which may be a SECDED codeword. The block counts how many chunks carry a clean codeword. Three or four clean chunks mean the line is protected. Fewer mean it is raw.

For a protected line, every chunk is decoded. A single flipped bit is repaired. A double flip is reported as uncorrectable. The 480 protected bits are then split into a 2-bit compression type and a 478-bit payload for a decompressor further down the path. Raw lines leave on the raw output untouched. The received line is always available on that raw output, so a consumer can pick either view.

The result is held in one output register with a valid/ready handshake. One line per cycle is accepted while the consumer keeps up.

Top module: `line_classifier`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Chunk k is line bits [128k+127:128k]. Its low 120 bits are data and its high 8 bits are check bits. Data bit i takes the (i+1)-th position in 1..127 that is not a power of two. Check bit j (0..6) is the XOR of the data bits whose position has bit j set. Check bit 7 gives the whole 128-bit chunk even parity.
- R3: If at least three chunks are clean (zero syndrome and even parity), `out_is_compressed` is 1. The protected vector is the four data fields with chunk 0 in the least significant bits. `out_type` is its bits [479:478] and `out_payload` is its bits [477:0].
- R4: If two or fewer chunks are clean, `out_is_compressed` is 0. In that case `out_type`, `out_payload`, `out_corrected` and `out_error` are all zero.
- R5: In a protected line, a chunk with odd parity is treated as a single error. If its syndrome names a data position, that data bit is flipped back. In every case `out_corrected` is 1 and the payload equals the original data.
- R6: In a protected line, a chunk with a nonzero syndrome and even parity sets `out_error`. Its data is passed through uncorrected, and it does not set `out_corrected`.
- R7: A chunk holding a correctable single error does not count as clean. So a line with two clean chunks and two single-error chunks is raw.
- R8: While `out_valid` is high and `out_ready` is low, every output stays stable and `in_ready` is low.
- R9: `out_raw` equals the accepted input line for every line, protected or raw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input line is offered |
| in_ready | output | 1 | Block can take a line this cycle |
| in_line | input | 512 | Line read from memory |
| out_valid | output | 1 | Result register holds a line |
| out_ready | input | 1 | Consumer takes the result |
| out_is_compressed | output | 1 | Line judged protected/compressed |
| out_type | output | 2 | Compression type field |
| out_payload | output | 478 | Corrected compressed payload |
| out_raw | output | 512 | Line as received |
| out_corrected | output | 1 | A single-bit error was repaired |
| out_error | output | 1 | An uncorrectable chunk was seen |

## Verification
The hardest case to reach from the ports is the one where the vote and the correction interact. This means lines that sit exactly on the three-clean threshold while the fourth chunk carries a single error, a double error, or random content. It also means lines with two clean chunks plus two chunks that would each be correctable. Random lines almost never land there. So the stimulus builds lines from a separately written encoder and then flips chosen bits in chosen chunks: data, low check bits and the parity bit. Separate lines splice clean codewords next to random chunks.

// File: rtl/line_classifier_pkg.sv
package line_classifier_pkg;

  localparam int SEG_DATA = 120;
  localparam int SYN_W    = 7;
  localparam int SEG_CHK  = SYN_W + 1;
  localparam int NUM_SEG  = 4;
  localparam int TYPE_W   = 2;

  localparam int CW_W     = SEG_DATA + SEG_CHK;
  localparam int LINE_W   = NUM_SEG * CW_W;
  localparam int PROT_W   = NUM_SEG * SEG_DATA;
  localparam int PAY_W    = PROT_W - TYPE_W;
  localparam int CNT_W    = $clog2(NUM_SEG + 1);

  // Hamming position of data bit idx: the (idx+1)-th non-power-of-two in 1..2^SYN_W-1
  function automatic logic [SYN_W-1:0] seg_pos(input int idx);
    int cnt;
    logic [SYN_W-1:0] r;
    cnt = 0;
    r   = '0;
    for (int p = 1; p < (1 << SYN_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) r = p[SYN_W-1:0];
        cnt++;
      end
    end
    return r;
  endfunction

  // Data bits that feed check bit j
  function automatic logic [SEG_DATA-1:0] chk_mask(input int j);
    logic [SEG_DATA-1:0] m;
    logic [SYN_W-1:0]    pos;
    for (int i = 0; i < SEG_DATA; i++) begin
      pos  = seg_pos(i);
      m[i] = pos[j];
    end
    return m;
  endfunction

  // Power-of-two (or zero) syndrome means the error, if any, is not in data
  function automatic logic names_data(input logic [SYN_W-1:0] s);
    return (s != '0) && ((s & (s - 1'b1)) != '0);
  endfunction

endpackage

// File: rtl/line_seg_decode.sv
module line_seg_decode
  import line_classifier_pkg::*;
(
  input  logic [CW_W-1:0]     cw,
  output logic                seg_ok,
  output logic                seg_fix,
  output logic                seg_bad,
  output logic [SEG_DATA-1:0] seg_data
);

  logic [SEG_DATA-1:0] dat;
  logic [SYN_W-1:0]    stored;
  logic [SYN_W-1:0]    calc;
  logic [SYN_W-1:0]    syn;
  logic                par_odd;
  logic [SEG_DATA-1:0] flip;

  assign dat     = cw[SEG_DATA-1:0];
  assign stored  = cw[SEG_DATA +: SYN_W];
  assign par_odd = ^cw;

  for (genvar j = 0; j < SYN_W; j++) begin : g_chk
    localparam logic [SEG_DATA-1:0] MASK = chk_mask(j);
    assign calc[j] = ^(dat & MASK);
  end

  assign syn = calc ^ stored;

  // Classification: only an untouched codeword votes
  assign seg_ok  = (syn == '0) && !par_odd;
  // Odd parity: single error (data, low check bit or parity bit)
  assign seg_fix = par_odd;
  // Even parity with nonzero syndrome: double error
  assign seg_bad = !par_odd && (syn != '0);

  for (genvar i = 0; i < SEG_DATA; i++) begin : g_flip
    localparam logic [SYN_W-1:0] POS = seg_pos(i);
    assign flip[i] = seg_fix && names_data(syn) && (syn == POS);
  end

  assign seg_data = dat ^ flip;

endmodule

// File: rtl/line_vote.sv
module line_vote
  import line_classifier_pkg::*;
#(
  parameter int VOTE_MIN = 3
)(
  input  logic [NUM_SEG-1:0] seg_ok,
  input  logic [NUM_SEG-1:0] seg_fix,
  input  logic [NUM_SEG-1:0] seg_bad,
  output logic [CNT_W-1:0]   ok_count,
  output logic               is_comp,
  output logic               any_fix,
  output logic               any_bad
);

  always_comb begin
    ok_count = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      ok_count = ok_count + CNT_W'(seg_ok[s]);
    end
  end

  assign is_comp = (ok_count >= CNT_W'(VOTE_MIN));
  assign any_fix = is_comp && (|seg_fix);
  assign any_bad = is_comp && (|seg_bad);

endmodule

// File: rtl/line_classifier.sv
module line_classifier
  import line_classifier_pkg::*;
#(
  parameter int VOTE_MIN = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LINE_W-1:0] in_line,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_compressed,
  output logic [TYPE_W-1:0] out_type,
  output logic [PAY_W-1:0]  out_payload,
  output logic [LINE_W-1:0] out_raw,
  output logic              out_corrected,
  output logic              out_error
);

  logic [NUM_SEG-1:0] seg_ok;
  logic [NUM_SEG-1:0] seg_fix;
  logic [NUM_SEG-1:0] seg_bad;
  logic [PROT_W-1:0]  prot;
  logic [CNT_W-1:0]   ok_count;
  logic               is_comp;
  logic               any_fix;
  logic               any_bad;
  logic               take;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    line_seg_decode u_dec (
      .cw      (in_line[s*CW_W +: CW_W]),
      .seg_ok  (seg_ok[s]),
      .seg_fix (seg_fix[s]),
      .seg_bad (seg_bad[s]),
      .seg_data(prot[s*SEG_DATA +: SEG_DATA])
    );
  end

  line_vote #(.VOTE_MIN(VOTE_MIN)) u_vote (
    .seg_ok  (seg_ok),
    .seg_fix (seg_fix),
    .seg_bad (seg_bad),
    .ok_count(ok_count),
    .is_comp (is_comp),
    .any_fix (any_fix),
    .any_bad (any_bad)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid         <= 1'b0;
      out_is_compressed <= 1'b0;
      out_type          <= '0;
      out_payload       <= '0;
      out_raw           <= '0;
      out_corrected     <= 1'b0;
      out_error         <= 1'b0;
    end else if (take) begin
      out_valid         <= 1'b1;
      out_is_compressed <= is_comp;
      out_type          <= is_comp ? prot[PROT_W-1 -: TYPE_W] : '0;
      out_payload       <= is_comp ? prot[PAY_W-1:0] : '0;
      out_raw           <= in_line;
      out_corrected     <= any_fix;
      out_error         <= any_bad;
    end else if (out_ready) begin
      out_valid         <= 1'b0;
    end
  end

  // R4: a raw result carries no decoded fields
  a_r4_raw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_compressed |->
      !out_corrected && !out_error && out_type == '0 && out_payload == '0);

  // R5 / R6: correction and error flags only on protected lines
  a_r5_flags_need_vote: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_corrected || out_error) |-> out_is_compressed);

  // R7: vote result agrees with the clean-chunk count at capture
  a_r7_vote_count: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_is_compressed == ($past(ok_count) >= CNT_W'(VOTE_MIN)));

  // R8: stalled result holds and blocks input
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_raw) &&
      $stable(out_payload) && $stable(out_is_compressed) &&
      $stable(out_corrected) && $stable(out_error) && $stable(out_type));

  a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9: raw view is the accepted line
  a_r9_raw_copy: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && out_raw == $past(in_line));

endmodule

// File: tb/line_classifier_test.sv
module line_classifier_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] in_line = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_is_compressed;
  logic [1:0]   out_type;
  logic [477:0] out_payload;
  logic [511:0] out_raw;
  logic         out_corrected;
  logic         out_error;

  line_classifier uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_compressed(out_is_compressed), .out_type(out_type),
    .out_payload(out_payload), .out_raw(out_raw),
    .out_corrected(out_corrected), .out_error(out_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int posmap[120];
  bit bp_on = 0;
  bit done = 0;
  bit mon_on = 0;
  string cur_tag = "";

  typedef struct packed {
    logic         comp;
    logic [1:0]   typ;
    logic [477:0] pay;
    logic [511:0] raw;
    logic         fix;
    logic         bad;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Hamming positions walked by a running counter
  initial begin
    int k;
    k = 0;
    for (int p = 1; p < 128; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        posmap[k] = p;
        k++;
      end
    end
  end

  function automatic logic [127:0] enc(input logic [119:0] d);
    int acc;
    logic [7:0] c;
    acc = 0;
    for (int i = 0; i < 120; i++) if (d[i]) acc = acc ^ posmap[i];
    c[6:0] = acc[6:0];
    c[7]   = (^d) ^ (^acc[6:0]);
    return {c, d};
  endfunction

  function automatic logic [511:0] mkline(input logic [1:0] t, input logic [477:0] p);
    logic [479:0] pr;
    logic [511:0] l;
    pr = {t, p};
    for (int s = 0; s < 4; s++) l[s*128 +: 128] = enc(pr[s*120 +: 120]);
    return l;
  endfunction

  function automatic exp_t model(input logic [511:0] ln);
    exp_t e;
    int okc, syn;
    bit par, fx, bd;
    logic [127:0] cw;
    logic [119:0] d;
    logic [479:0] pr;
    okc = 0; fx = 0; bd = 0;
    for (int s = 0; s < 4; s++) begin
      cw = ln[s*128 +: 128];
      syn = 0;
      for (int i = 0; i < 120; i++) if (cw[i]) syn = syn ^ posmap[i];
      for (int j = 0; j < 7; j++) if (cw[120+j]) syn = syn ^ (1 << j);
      par = ^cw;
      d = cw[119:0];
      if (syn == 0 && !par) okc++;
      else if (par) begin
        fx = 1;
        for (int i = 0; i < 120; i++) if (posmap[i] == syn) d[i] = ~d[i];
      end else bd = 1;
      pr[s*120 +: 120] = d;
    end
    e.raw  = ln;
    e.comp = (okc >= 3);
    e.typ  = e.comp ? pr[479:478] : 2'b0;
    e.pay  = e.comp ? pr[477:0] : '0;
    e.fix  = e.comp && fx;
    e.bad  = e.comp && bd;
    return e;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic send(input logic [511:0] l, input string tag);
    bit took;
    in_line  = l;
    cur_tag  = tag;
    in_valid = 1'b1;
    do begin
      @(negedge clk);
      took = in_ready;
      @(posedge clk);
      #1;
    end while (!took);
    in_valid = 1'b0;
  endtask

  // Monitor: compare on every clock at the falling edge
  exp_t snap;
  bit   stall_prev = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (stall_prev) begin
        check(out_valid, "R8", "valid held", {511'b0, out_valid}, 512'b1);
        check(out_raw == snap.raw && out_payload == snap.pay &&
              out_is_compressed == snap.comp && out_type == snap.typ &&
              out_corrected == snap.fix && out_error == snap.bad,
              "R8", "outputs held", out_raw, snap.raw);
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(0, "R9", "unexpected output", out_raw, 512'b0);
        end else begin
          exp_t e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(out_is_compressed == e.comp, t, "class",
                {511'b0, out_is_compressed}, {511'b0, e.comp});
          check(out_type == e.typ && out_payload == e.pay, t, "payload",
                {32'b0, out_type, out_payload}, {32'b0, e.typ, e.pay});
          check(out_corrected == e.fix && out_error == e.bad, t, "flags",
                {510'b0, out_corrected, out_error}, {510'b0, e.fix, e.bad});
          check(out_raw == e.raw, "R9", "raw copy", out_raw, e.raw);
        end
      end
      stall_prev = out_valid && !out_ready;
      if (stall_prev) begin
        check(!in_ready, "R8", "input blocked", {511'b0, in_ready}, 512'b0);
        snap.raw = out_raw; snap.pay = out_payload; snap.comp = out_is_compressed;
        snap.typ = out_type; snap.fix = out_corrected; snap.bad = out_error;
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(in_line));
        tagq.push_back(cur_tag);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic run_set();
    logic [511:0] l;
    int b0, b1;
    // R2 R3: clean encoded lines, every type value
    for (int k = 0; k < 8; k++) begin
      l = rnd512();
      send(mkline(k[1:0], l[477:0]), "R2 R3");
    end
    // R5: one single error per line, data / low check / parity bit
    for (int s = 0; s < 4; s++) begin
      l = rnd512();
      l = mkline(l[479:478], l[477:0]);
      l[s*128 + ($urandom % 120)] ^= 1'b1;
      send(l, "R5");
      l = rnd512();
      l = mkline(l[479:478], l[477:0]);
      l[s*128 + 120 + ($urandom % 7)] ^= 1'b1;
      send(l, "R5");
      l = rnd512();
      l = mkline(l[479:478], l[477:0]);
      l[s*128 + 127] ^= 1'b1;
      send(l, "R5");
    end
    // R6: double error in one chunk
    for (int s = 0; s < 4; s++) begin
      l = rnd512();
      l = mkline(l[479:478], l[477:0]);
      b0 = $urandom % 128;
      b1 = (b0 + 1 + ($urandom % 127)) % 128;
      l[s*128 + b0] ^= 1'b1;
      l[s*128 + b1] ^= 1'b1;
      send(l, "R6");
    end
    // R7: two chunks with single errors leave only two clean
    for (int k = 0; k < 4; k++) begin
      l = rnd512();
      l = mkline(l[479:478], l[477:0]);
      l[(k % 4)*128 + ($urandom % 128)] ^= 1'b1;
      l[((k + 1) % 4)*128 + ($urandom % 128)] ^= 1'b1;
      send(l, "R7");
    end
    // R4: random lines and two-clean splices
    for (int k = 0; k < 6; k++) send(rnd512(), "R4");
    for (int k = 0; k < 4; k++) begin
      l = rnd512();
      l[0 +: 128]   = enc(l[0 +: 120]);
      l[256 +: 128] = enc(l[256 +: 120]);
      send(l, "R4");
    end
    // R3: three clean plus a random chunk still votes protected
    for (int k = 0; k < 4; k++) begin
      l = rnd512();
      for (int s = 0; s < 4; s++) if (s != k) l[s*128 +: 128] = enc(l[s*128 +: 120]);
      send(l, "R3");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", "reset state",
          {510'b0, out_valid, in_ready}, {510'b0, 1'b0, 1'b1});
    mon_on = 1;
    @(posedge clk);
    #1;
    run_set();
    bp_on = 1;
    run_set();
    bp_on = 0;
    while (expq.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule